// File: doc/BRIEF.md
# Refresh and Real-Time Clock Ticker

This block services a periodic timer wakeup. On every tick strobe it issues one memory refresh reference and presents the row pointer for that reference. It then steps the pointer on to the next group of rows. In the same cycle it adds a programmable 32-bit fixed-point constant, supplied as a high and a low word, to a two-word clock accumulator. The low word carries 6 fraction bits below the visible clock LSB. The constant is chosen as 6.72·C/H, where C is the tick period in processor cycles and H is the clock frequency in MHz. For example, 2560 cycles at 40 MHz gives high word 16'h01AE and low word 16'h147A.

When the upper accumulator word carries out, the block increments a 16-bit tick counter kept in memory. It does this as a read-modify-write over a simple request/ready handshake. Carries that arrive while an increment is in flight are queued. Refresh never waits on the memory increment.

Top module: `rtc_refresh_ticker`

## Requirements
- R1: After reset, refreshReq, memReq and memWe are 0, and refreshRow, clkLoWord and clkHiWord are all zero.
- R2: A tick sampled high at a clock edge makes refreshReq 1 for exactly the following cycle. refreshRow then shows the pointer value from before the tick, and the pointer advances by ROW_STEP (default 16) modulo 2^16. The first reference after reset uses row 0.
- R3: On a tick, clkLoWord becomes (clkLoWord + constLo) mod 2^16.
- R4: On a tick, clkHiWord becomes (clkHiWord + constHi + c) mod 2^16, where c is the carry out of the R3 addition.
- R5: Each carry out of the R4 addition causes exactly one increment. The block issues a read (memReq=1, memWe=0), then a write (memReq=1, memWe=1) with memWdata equal to the read data plus 1, modulo 2^16.
- R6: A request holds memReq and its memWe value unchanged until memReady is sampled high. memRdata is taken in the cycle the read completes.
- R7: Ticks during an outstanding increment still refresh and accumulate. Up to 2^PEND_W−1 further carries are queued and served in order, one read-modify-write each.
- R8: In a cycle without a tick, refreshReq is 0 and refreshRow, clkLoWord and clkHiWord hold.
- R9: With both constant words zero, the accumulator never changes and no memory request is made, but refresh references and the row pointer advance as usual, including wrap from 16'hFFF0 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer wakeup strobe, one cycle per period |
| constHi | input | 16 | Upper word of the per-tick clock constant |
| constLo | input | 16 | Lower word of the per-tick clock constant |
| memReady | input | 1 | Memory accepts/completes the current request |
| memRdata | input | 16 | Tick counter value returned by a read |
| refreshReq | output | 1 | One-cycle refresh reference request |
| refreshRow | output | 16 | Row address for the current refresh reference |
| clkLoWord | output | 16 | Lower accumulator word (6 fraction bits at the bottom) |
| clkHiWord | output | 16 | Upper accumulator word |
| memReq | output | 1 | Tick-counter access request |
| memWe | output | 1 | 0 = read, 1 = write of the current request |
| memWdata | output | 16 | Incremented tick counter for the write |

## Verification
The assertions assume three things about the inputs. Memory eventually raises memReady. memRdata is valid in the cycle a read completes. Carries never arrive faster than the increment queue can absorb, so the queue never saturates. The stimulus meets these by driving memReady from a pseudo-random pattern that is high about half the time, and by returning the bench's own memory word on every read. It spaces ticks against large constants so that pending increments drain faster than carries occur. Back-to-back tick bursts use small constants, which exercises refresh while an increment is stalled without overfilling the queue.

// File: rtl/rtc_ticker_pkg.sv
package rtc_ticker_pkg;
  typedef struct packed {
    logic advance;   // apply one tick: refresh step and accumulate
    logic capture;   // read completed: latch memRdata + 1
  } dpStrobes_t;

  typedef enum logic [1:0] {
    RMW_IDLE  = 2'd0,
    RMW_READ  = 2'd1,
    RMW_WRITE = 2'd2
  } rmwState_t;
endpackage

// File: rtl/rtc_ticker_ctrl.sv
module rtc_ticker_ctrl
  import rtc_ticker_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       carryOut,
  input  logic       memReady,
  output dpStrobes_t strobes,
  output logic       memReq,
  output logic       memWe
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  rmwState_t         state, stateNext;
  logic [PEND_W-1:0] pendCnt;
  logic              startRmw;
  logic              addPend;

  assign startRmw = (state == RMW_IDLE) && (pendCnt != '0);
  assign addPend  = carryOut && (pendCnt != PEND_MAX);

  always_comb begin
    stateNext = state;
    unique case (state)
      RMW_IDLE:  if (startRmw) stateNext = RMW_READ;
      RMW_READ:  if (memReady) stateNext = RMW_WRITE;
      RMW_WRITE: if (memReady) stateNext = RMW_IDLE;
      default:   stateNext = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RMW_IDLE;
      pendCnt <= '0;
    end else begin
      state   <= stateNext;
      pendCnt <= pendCnt + PEND_W'(addPend) - PEND_W'(startRmw);
    end
  end

  assign memReq          = (state != RMW_IDLE);
  assign memWe           = (state == RMW_WRITE);
  assign strobes.advance = tick;
  assign strobes.capture = (state == RMW_READ) && memReady;

  // R6: an unaccepted request stays up with the same direction
  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && (memWe == $past(memWe)));

  // R5: a write phase is entered only after a completed read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(memReq && memReady));

  // R5: a carry seen while idle with an empty queue leads to a request
  a_r5_carry_starts_rmw: assert property (@(posedge clk) disable iff (!rstN)
    carryOut && !memReq && (pendCnt == '0) |=> ##1 memReq);
endmodule

// File: rtl/rtc_ticker_datapath.sv
module rtc_ticker_datapath
  import rtc_ticker_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ROW_W    = 16,
  parameter int ROW_STEP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [WORD_W-1:0] constHi,
  input  logic [WORD_W-1:0] constLo,
  input  logic [WORD_W-1:0] memRdata,
  output logic              carryOut,
  output logic              refreshReq,
  output logic [ROW_W-1:0]  refreshRow,
  output logic [WORD_W-1:0] clkLoWord,
  output logic [WORD_W-1:0] clkHiWord,
  output logic [WORD_W-1:0] memWdata
);
  localparam logic [ROW_W-1:0] STEP = ROW_W'(ROW_STEP);

  logic [ROW_W-1:0]  rowPtr;
  logic [WORD_W-1:0] sumLo, sumHi;
  logic              carryLo, carryHi;

  assign {carryLo, sumLo} = {1'b0, clkLoWord} + {1'b0, constLo};
  assign {carryHi, sumHi} = {1'b0, clkHiWord} + {1'b0, constHi} + {{WORD_W{1'b0}}, carryLo};
  assign carryOut = strobes.advance && carryHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowPtr     <= '0;
      refreshRow <= '0;
      refreshReq <= 1'b0;
      clkLoWord  <= '0;
      clkHiWord  <= '0;
      memWdata   <= '0;
    end else begin
      refreshReq <= strobes.advance;
      if (strobes.advance) begin
        refreshRow <= rowPtr;
        rowPtr     <= rowPtr + STEP;
        clkLoWord  <= sumLo;
        clkHiWord  <= sumHi;
      end
      if (strobes.capture) memWdata <= memRdata + 1'b1;
    end
  end

  // R2: the pointer moves by one step per tick and only on ticks
  a_r2_row_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> rowPtr == $past(rowPtr) + STEP);
  // R2: a refresh request always follows a tick
  a_r2_req_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> $past(strobes.advance));
  // R8: without a tick the clock words and row hold
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(clkLoWord) && $stable(clkHiWord) && $stable(rowPtr));
  // R9: zero constant leaves the accumulator untouched
  a_r9_zero_const: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance && constHi == '0 && constLo == '0 |=> $stable(clkLoWord) && $stable(clkHiWord));
endmodule

// File: rtl/rtc_refresh_ticker.sv
module rtc_refresh_ticker
  import rtc_ticker_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ROW_W    = 16,
  parameter int ROW_STEP = 16,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [WORD_W-1:0] constHi,
  input  logic [WORD_W-1:0] constLo,
  input  logic              memReady,
  input  logic [WORD_W-1:0] memRdata,
  output logic              refreshReq,
  output logic [ROW_W-1:0]  refreshRow,
  output logic [WORD_W-1:0] clkLoWord,
  output logic [WORD_W-1:0] clkHiWord,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memWdata
);
  dpStrobes_t strobes;
  logic       carryOut;

  rtc_ticker_ctrl #(.PEND_W(PEND_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .carryOut (carryOut),
    .memReady (memReady),
    .strobes  (strobes),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  rtc_ticker_datapath #(
    .WORD_W  (WORD_W),
    .ROW_W   (ROW_W),
    .ROW_STEP(ROW_STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .constHi   (constHi),
    .constLo   (constLo),
    .memRdata  (memRdata),
    .carryOut  (carryOut),
    .refreshReq(refreshReq),
    .refreshRow(refreshRow),
    .clkLoWord (clkLoWord),
    .clkHiWord (clkHiWord),
    .memWdata  (memWdata)
  );
endmodule

// File: tb/rtc_refresh_ticker_tb.sv
`timescale 1ns/1ps
module rtc_refresh_ticker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] constHi = '0, constLo = '0;
  logic        memReady = 1'b0;
  logic [15:0] memRdata;
  logic        refreshReq, memReq, memWe;
  logic [15:0] refreshRow, clkLoWord, clkHiWord, memWdata;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rtc_refresh_ticker u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .constHi(constHi), .constLo(constLo),
    .memReady(memReady), .memRdata(memRdata), .refreshReq(refreshReq),
    .refreshRow(refreshRow), .clkLoWord(clkLoWord), .clkHiWord(clkHiWord),
    .memReq(memReq), .memWe(memWe), .memWdata(memWdata)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [15:0] mPtr = '0, mRow = '0, memVal = 16'h7FFE, memBase = 16'h7FFE;
  logic [31:0] mAcc = '0;
  logic [32:0] mSum;
  bit          mReq = 0;
  int          expCarries = 0, writes = 0;
  bit          prevHold = 0, prevWe = 0;
  bit          strictRef = 1;

  assign memRdata = memVal;

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = '0; mRow = '0; mAcc = '0; mReq = 0;
      prevHold = 0;
    end else begin
      mReq = tick;
      if (tick) begin
        mRow = mPtr;
        mPtr = mPtr + 16'd16;
        mSum = {1'b0, mAcc} + {1'b0, constHi, constLo};
        mAcc = mSum[31:0];
        if (mSum[32]) expCarries++;
      end
      if (memReq && memReady && memWe) begin
        check(memWdata == memVal + 16'd1, "R5 write data", memWdata, memVal + 16'd1);
        memVal <= memWdata;
        writes++;
      end
      prevHold = memReq && !memReady;
      prevWe   = memWe;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(refreshReq == mReq, "R2/R8 refreshReq", refreshReq, mReq);
      check(refreshRow == mRow, "R2 refreshRow", refreshRow, mRow);
      check(clkLoWord == mAcc[15:0], "R3 clkLoWord", clkLoWord, mAcc[15:0]);
      check(clkHiWord == mAcc[31:16], "R4 clkHiWord", clkHiWord, mAcc[31:16]);
      if (prevHold)
        check(memReq && memWe == prevWe, "R6 request held", {memReq, memWe}, {1'b1, prevWe});
    end
  end

  // Pseudo-random ready pattern
  logic [15:0] lfsr = 16'hACE1;
  bit readyOn = 1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady <= readyOn && lfsr[0];
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (writes != expCarries || memReq); i++) @(negedge clk);
    @(negedge clk);
    check(writes == expCarries, "R5/R7 increments served", writes, expCarries);
    check(memVal == 16'(memBase + expCarries), "R5 counter value", memVal, 16'(memBase + expCarries));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(refreshReq == 0 && memReq == 0 && memWe == 0, "R1 reset strobes", {refreshReq, memReq, memWe}, 0);
    check(refreshRow == 0 && clkLoWord == 0 && clkHiWord == 0, "R1 reset words",
          {refreshRow, clkLoWord, clkHiWord}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9 zero constants: refresh runs through a full pointer wrap, no memory traffic
    for (int i = 0; i < 4100; i++) begin
      @(negedge clk); tick = 1'b1;
      check(memReq == 0, "R9 no memory request", memReq, 0);
      @(negedge clk); tick = 1'b0;
    end
    check(refreshRow == 16'h0030, "R9 row wrapped", refreshRow, 16'h0030);
    check(writes == 0, "R9 no increments", writes, 0);

    // R3/R4/R5: 2560-cycle period at 40 MHz constant
    constHi = 16'h01AE; constLo = 16'h147A;
    ticks(700, 1);
    drain();

    // R5/R7: large constant, carries on most ticks, spaced to keep the queue short
    constHi = 16'hF000; constLo = 16'hFFFF;
    ticks(120, 8);
    drain();

    // R7: back-to-back ticks with memory stalled; refresh continues meanwhile
    constHi = 16'h4000; constLo = 16'h0001;
    readyOn = 0;
    ticks(1, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
    check(memReq == 1, "R7 increment pending during burst", memReq, 1);
    readyOn = 1;
    drain();

    // R8: idle cycles with nonzero constant
    constHi = 16'h1234; constLo = 16'h5678;
    repeat (20) @(negedge clk);
    drain();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule